// File: doc/BRIEF.md
# Predicated Mask Logic Unit

This unit executes the bitwise logical instructions that a scalable-vector processor applies to its mask (predicate) registers. Each call hands it a 32-bit instruction word plus three mask operands already read from the register file: a first source, a second source and a governing mask. The unit decodes the word, forms a destination mask with one bit per element and, when the instruction asks for it, produces the N, Z, C and V condition flags.

The mask width is a parameter. A separate active-length input states how many low-order elements take part; governing bits at or above that length count as zero and destination bits there are written as zero. Every operation except the merge (select) is gated by the governing mask; the select takes the first source where the governing bit is set and the second source elsewhere. Flags come from the result bits at the lowest and highest governing-active positions and from whether any result bit is set. Results appear one clock after a single-cycle input strobe, with no handshake.

Top module: `pmask_logic_unit`

## Requirements
- R1: `res_valid` is high exactly in the cycle after each cycle with `op_valid` high, and low otherwise; a synchronous active-high `rst` clears every output to zero.
- R2: An instruction is legal only when bits 31:24 equal 8'h25, bits 21:20 equal 2'b00 and bits 15:14 equal 2'b01; any other word gives `undef`=1, `dst_mask`=0, `dst_idx`=0, `flags_valid`=0 and unchanged flags. For a legal word `dst_idx` is bits 3:0.
- R3: Bit 23 = 0 selects the group {bits 9,4 = 00 AND n&m, 01 BIC n&~m, 10 EOR n^m, 11 SEL}; bit 23 = 1 selects {00 ORR n|m, 01 ORN n|~m, 10 NOR ~(n|m), 11 NAND ~(n&m)}. Every such result is ANDed with the effective governing mask.
- R4: SEL produces (n&g)|(m&~g) with the effective governing mask g and is not further gated.
- R5: Governing bits at index >= `act_len` are treated as 0 for result and flags; destination bits at index >= `act_len` are 0; an `act_len` above the mask width acts as the full width.
- R6: With bit 22 set, `flag_n` equals the result bit at the lowest set position of the effective governing mask, and is 0 when that mask is empty.
- R7: With bit 22 set, `flag_z` is 1 exactly when the destination mask has no set bit.
- R8: With bit 22 set, `flag_c` is 1 when the result bit at the highest set governing position is 0, or when the effective governing mask is empty; `flag_v` is always 0.
- R9: A legal instruction with bit 22 clear writes the destination but leaves all four flags unchanged and gives `flags_valid`=0; a flag-setting one gives `flags_valid`=1.
- R10: The word with bits 23:22 = 01 and bits 9,4 = 11 (flag-setting select) is reported as undefined with the R2 outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One-cycle strobe: operands and instruction present |
| instr | input | 32 | Instruction word |
| src_n | input | PW | First source mask |
| src_m | input | PW | Second source mask |
| gov | input | PW | Governing mask |
| act_len | input | LENW | Number of active low-order elements |
| res_valid | output | 1 | Result strobe, one cycle after `op_valid` |
| undef | output | 1 | Instruction not recognised (with `res_valid`) |
| dst_idx | output | 4 | Destination register number |
| dst_mask | output | PW | Destination mask |
| flags_valid | output | 1 | Flags were written by this result |
| flag_n | output | 1 | N flag |
| flag_z | output | 1 | Z flag |
| flag_c | output | 1 | C flag |
| flag_v | output | 1 | V flag |

## Verification
The assertions watch, on every cycle, the one-cycle result latency, that strobes stay low between results, that an undefined word never writes flags, that destination bits above the active length are zero, that flags hold when not written, and the consistency of Z with the destination and of C and N with Z. Only the bench scenarios can show that each of the eight operations and the select merge produce the right bits, that N and C pick the first and last governing positions, and that the decode rejects each malformed field and the flag-setting select.

// File: rtl/pml_pkg.sv
package pml_pkg;

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_BIC  = 3'd1,
        OP_EOR  = 3'd2,
        OP_SEL  = 3'd3,
        OP_ORR  = 3'd4,
        OP_ORN  = 3'd5,
        OP_NOR  = 3'd6,
        OP_NAND = 3'd7
    } pml_op_e;

    typedef struct packed {
        logic       legal;
        logic       setf;
        pml_op_e    op;
        logic [3:0] dst;
    } pml_dec_t;

    // One element of a predicated logical operation.
    function automatic logic elem_op(pml_op_e op, logic n, logic m, logic g);
        logic r;
        case (op)
            OP_AND:  r = (n & m) & g;
            OP_BIC:  r = (n & ~m) & g;
            OP_EOR:  r = (n ^ m) & g;
            OP_SEL:  r = (n & g) | (m & ~g);
            OP_ORR:  r = (n | m) & g;
            OP_ORN:  r = (n | ~m) & g;
            OP_NOR:  r = ~(n | m) & g;
            default: r = ~(n & m) & g;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pml_decode.sv
module pml_decode
    import pml_pkg::*;
(
    input  logic [31:0] instr,
    output pml_dec_t    dec
);
    logic       fixed_ok;
    logic       grp;
    logic [1:0] sub;

    always_comb begin
        fixed_ok = (instr[31:24] == 8'h25) && (instr[21:20] == 2'b00)
                && (instr[15:14] == 2'b01);
        grp      = instr[23];
        sub      = {instr[9], instr[4]};
        dec.setf = instr[22];
        dec.op   = pml_op_e'({grp, sub});
        dec.dst  = instr[3:0];
        // R10: the flag-setting merge has no encoding
        dec.legal = fixed_ok && !(!grp && instr[22] && (sub == 2'b11));
    end
endmodule

// File: rtl/pml_active_mask.sv
module pml_active_mask #(
    parameter int PW   = 16,
    parameter int LENW = $clog2(PW + 1)
) (
    input  logic [LENW-1:0] act_len,
    output logic [PW-1:0]   act_mask
);
    // R5: element i is active when i < act_len; larger lengths saturate
    for (genvar i = 0; i < PW; i++) begin : g_bit
        assign act_mask[i] = (act_len > LENW'(i));
    end
endmodule

// File: rtl/pml_compute.sv
module pml_compute
    import pml_pkg::*;
#(
    parameter int PW = 16
) (
    input  pml_op_e       op,
    input  logic [PW-1:0] n_in,
    input  logic [PW-1:0] m_in,
    input  logic [PW-1:0] g_eff,
    output logic [PW-1:0] res
);
    for (genvar i = 0; i < PW; i++) begin : g_elem
        assign res[i] = elem_op(op, n_in[i], m_in[i], g_eff[i]);
    end
endmodule

// File: rtl/pml_flags.sv
module pml_flags #(
    parameter int PW = 16
) (
    input  logic [PW-1:0] res,
    input  logic [PW-1:0] g_eff,
    output logic          n_flag,
    output logic          z_flag,
    output logic          c_flag
);
    logic seen;

    always_comb begin
        // R6: result bit at the lowest governing-active element
        n_flag = 1'b0;
        seen   = 1'b0;
        for (int i = 0; i < PW; i++) begin
            if (g_eff[i] && !seen) begin
                n_flag = res[i];
                seen   = 1'b1;
            end
        end
        // R8: inverted result bit at the highest governing-active element
        c_flag = 1'b1;
        for (int i = 0; i < PW; i++) begin
            if (g_eff[i]) begin
                c_flag = ~res[i];
            end
        end
        // R7
        z_flag = ~|res;
    end
endmodule

// File: rtl/pmask_logic_unit.sv
module pmask_logic_unit
    import pml_pkg::*;
#(
    parameter int PW   = 16,
    parameter int LENW = $clog2(PW + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [31:0]     instr,
    input  logic [PW-1:0]   src_n,
    input  logic [PW-1:0]   src_m,
    input  logic [PW-1:0]   gov,
    input  logic [LENW-1:0] act_len,
    output logic            res_valid,
    output logic            undef,
    output logic [3:0]      dst_idx,
    output logic [PW-1:0]   dst_mask,
    output logic            flags_valid,
    output logic            flag_n,
    output logic            flag_z,
    output logic            flag_c,
    output logic            flag_v
);
    typedef struct packed {
        logic          vld;
        logic          und;
        logic [3:0]    idx;
        logic [PW-1:0] msk;
        logic          fvld;
        logic          n;
        logic          z;
        logic          c;
        logic          v;
    } state_t;

    state_t   st_d, st_q;
    pml_dec_t dec;
    logic [PW-1:0] act_mask, g_eff, res;
    logic          fn, fz, fc;

    pml_decode u_dec (.instr(instr), .dec(dec));

    pml_active_mask #(.PW(PW), .LENW(LENW)) u_act (
        .act_len(act_len), .act_mask(act_mask)
    );

    assign g_eff = gov & act_mask;

    pml_compute #(.PW(PW)) u_cmp (
        .op(dec.op), .n_in(src_n), .m_in(src_m), .g_eff(g_eff), .res(res)
    );

    pml_flags #(.PW(PW)) u_flg (
        .res(res), .g_eff(g_eff), .n_flag(fn), .z_flag(fz), .c_flag(fc)
    );

    always_comb begin
        st_d      = st_q;
        st_d.vld  = op_valid;
        st_d.und  = 1'b0;
        st_d.fvld = 1'b0;
        if (op_valid) begin
            if (!dec.legal) begin
                st_d.und = 1'b1;
                st_d.idx = '0;
                st_d.msk = '0;
            end else begin
                st_d.idx = dec.dst;
                st_d.msk = res & act_mask;
                if (dec.setf) begin
                    st_d.fvld = 1'b1;
                    st_d.n    = fn;
                    st_d.z    = fz;
                    st_d.c    = fc;
                    st_d.v    = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid   = st_q.vld;
    assign undef       = st_q.und;
    assign dst_idx     = st_q.idx;
    assign dst_mask    = st_q.msk;
    assign flags_valid = st_q.fvld;
    assign flag_n      = st_q.n;
    assign flag_z      = st_q.z;
    assign flag_c      = st_q.c;
    assign flag_v      = st_q.v;

    // ---------------- assertions ----------------
    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> res_valid);
    p_idle_r1: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !res_valid && !undef && !flags_valid);
    p_undef_noflags_r2: assert property (@(posedge clk) disable iff (rst)
        undef |-> !flags_valid && (dst_mask == '0));
    p_above_len_zero_r5: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> ((dst_mask & ~$past(act_mask)) == '0));
    p_z_matches_dst_r7: assert property (@(posedge clk) disable iff (rst)
        flags_valid |-> (flag_z == (dst_mask == '0)));
    p_c_when_zero_r8: assert property (@(posedge clk) disable iff (rst)
        flags_valid && flag_z |-> flag_c && !flag_n && !flag_v);
    p_flags_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !st_d.fvld |=> $stable({flag_n, flag_z, flag_c, flag_v}));
endmodule

// File: tb/pmask_logic_unit_tb.sv
module pmask_logic_unit_tb;
    localparam int PW   = 16;
    localparam int LENW = $clog2(PW + 1);

    logic            clk = 1'b0;
    logic            rst;
    logic            op_valid;
    logic [31:0]     instr;
    logic [PW-1:0]   src_n, src_m, gov;
    logic [LENW-1:0] act_len;
    logic            res_valid, undef, flags_valid;
    logic [3:0]      dst_idx;
    logic [PW-1:0]   dst_mask;
    logic            flag_n, flag_z, flag_c, flag_v;

    always #5 clk = ~clk;

    pmask_logic_unit #(.PW(PW), .LENW(LENW)) u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .instr(instr),
        .src_n(src_n), .src_m(src_m), .gov(gov), .act_len(act_len),
        .res_valid(res_valid), .undef(undef), .dst_idx(dst_idx),
        .dst_mask(dst_mask), .flags_valid(flags_valid), .flag_n(flag_n),
        .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    typedef struct {
        logic          und;
        logic [3:0]    idx;
        logic [PW-1:0] msk;
        logic          fv;
        logic [3:0]    nzcv;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   vectors = 0;
    int   miscompares = 0;
    logic [3:0] mdl_nzcv = 4'b0000;

    // Instruction builder: group bit 23, flag bit 22, op bits 9 and 4
    function automatic logic [31:0] mk(logic grp, logic s, logic [1:0] o, logic [3:0] d);
        return {8'h25, grp, s, 2'b00, 4'h3, 2'b01, 4'h7, o[1], 4'h5, o[0], d};
    endfunction

    function automatic logic ref_bit(logic [2:0] code, logic n, logic m, logic g);
        case (code)
            3'd0: return n && m && g;
            3'd1: return n && !m && g;
            3'd2: return (n != m) && g;
            3'd3: return g ? n : m;
            3'd4: return (n || m) && g;
            3'd5: return (n || !m) && g;
            3'd6: return !(n || m) && g;
            default: return !(n && m) && g;
        endcase
    endfunction

    task automatic apply(input logic [31:0] ins, input logic [PW-1:0] a, b, g,
                         input int len, input string tag);
        exp_t e;
        logic legal;
        logic [2:0] code;
        logic [PW-1:0] r;
        int lo, hi;
        @(negedge clk);
        op_valid = 1'b1; instr = ins; src_n = a; src_m = b; gov = g;
        act_len = LENW'(len);
        legal = (ins[31:24] == 8'h25) && (ins[21:20] == 2'b00) && (ins[15:14] == 2'b01)
             && !(ins[23:22] == 2'b01 && ins[9] && ins[4]);
        code = {ins[23], ins[9], ins[4]};
        e.tag = tag; e.fv = 1'b0; e.und = !legal;
        e.idx = legal ? ins[3:0] : 4'h0;
        r = '0; lo = -1; hi = -1;
        for (int i = 0; i < PW; i++) begin
            logic ge;
            ge = g[i] && (i < len);
            if (i < len) r[i] = ref_bit(code, a[i], b[i], ge);
            if (ge && lo < 0) lo = i;
            if (ge) hi = i;
        end
        e.msk = legal ? r : '0;
        if (legal && ins[22]) begin
            e.fv = 1'b1;
            mdl_nzcv[3] = (lo >= 0) ? r[lo] : 1'b0;
            mdl_nzcv[2] = (r == '0);
            mdl_nzcv[1] = (hi >= 0) ? !r[hi] : 1'b1;
            mdl_nzcv[0] = 1'b0;
        end
        e.nzcv = mdl_nzcv;
        q.push_back(e);
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            op_valid = 1'b0;
        end
    endtask

    // Monitor / scoreboard
    always @(posedge clk) begin
        #2;
        if (!rst && res_valid) begin
            exp_t e;
            vectors++;
            if (q.size() == 0) begin
                miscompares++;
                $display("FAIL R1: unexpected res_valid, actual 1 expected 0");
            end else begin
                e = q.pop_front();
                if (undef !== e.und || dst_idx !== e.idx || dst_mask !== e.msk ||
                    flags_valid !== e.fv ||
                    {flag_n, flag_z, flag_c, flag_v} !== e.nzcv) begin
                    miscompares++;
                    $display("FAIL %s: actual und=%b idx=%h msk=%h fv=%b nzcv=%b expected und=%b idx=%h msk=%h fv=%b nzcv=%b",
                             e.tag, undef, dst_idx, dst_mask, flags_valid,
                             {flag_n, flag_z, flag_c, flag_v}, e.und, e.idx,
                             e.msk, e.fv, e.nzcv);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; instr = '0; src_n = '0; src_m = '0;
        gov = '0; act_len = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        vectors++;
        if ({res_valid, undef, dst_idx, dst_mask, flags_valid, flag_n, flag_z, flag_c, flag_v} !== '0) begin
            miscompares++;
            $display("FAIL R1: reset outputs actual %h expected 0", dst_mask);
        end

        // R3 / R4: every operation, non-flag form, full length
        for (int o = 0; o < 8; o++) begin
            apply(mk(o[2], 1'b0, o[1:0], 4'(o + 1)), 16'hF0CC, 16'hAAAA, 16'h5F3C, 16,
                  (o == 3) ? "R4 sel merge" : "R3 op gated");
        end
        idle(2);
        // R6/R7/R8: flag-setting forms
        for (int o = 0; o < 8; o++) begin
            if (o != 3)
                apply(mk(o[2], 1'b1, o[1:0], 4'hA), 16'h8421, 16'h1248, 16'h0FF0, 16,
                      "R6 R7 R8 flags");
        end
        apply(mk(1'b0, 1'b1, 2'b00, 4'h2), 16'h0001, 16'h0001, 16'h8001, 16, "R6 first bit set");
        apply(mk(1'b0, 1'b1, 2'b00, 4'h2), 16'h8000, 16'h8000, 16'h8001, 16, "R8 last bit set, C=0");
        apply(mk(1'b1, 1'b1, 2'b00, 4'h2), 16'hFFFF, 16'hFFFF, 16'h0000, 16, "R8 empty gov C=1 N=0");
        apply(mk(1'b0, 1'b1, 2'b10, 4'h2), 16'h1234, 16'h1234, 16'hFFFF, 16, "R7 zero result");
        // R9: non-flag op after flags set keeps them
        apply(mk(1'b1, 1'b0, 2'b11, 4'h6), 16'h0000, 16'h0000, 16'hFFFF, 16, "R9 flags held");
        idle(1);
        // R5: active length
        apply(mk(1'b1, 1'b1, 2'b00, 4'h3), 16'hFFFF, 16'h0000, 16'hFFFF, 5, "R5 len 5");
        apply(mk(1'b0, 1'b0, 2'b11, 4'h3), 16'h0000, 16'hFFFF, 16'hFFFF, 5, "R5 sel beyond len");
        apply(mk(1'b1, 1'b1, 2'b00, 4'h3), 16'hFFFF, 16'hFFFF, 16'hFFFF, 0, "R5 len 0");
        apply(mk(1'b1, 1'b1, 2'b01, 4'h3), 16'h7FFE, 16'h0000, 16'hFFFF, 20, "R5 len above width");
        // R2 / R10: undefined words
        apply(mk(1'b0, 1'b1, 2'b11, 4'h9), 16'hFFFF, 16'hFFFF, 16'hFFFF, 16, "R10 flag-setting sel");
        apply(mk(1'b0, 1'b0, 2'b00, 4'h9) ^ 32'h0100_0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16, "R2 bad top bits");
        apply(mk(1'b0, 1'b0, 2'b00, 4'h9) | 32'h0010_0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16, "R2 bad bit 20");
        apply(mk(1'b0, 1'b0, 2'b00, 4'h9) ^ 32'h0000_C000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16, "R2 bad bits 15:14");
        apply(mk(1'b1, 1'b0, 2'b00, 4'hF), 16'h00FF, 16'h0F0F, 16'hFFFF, 16, "R2 dst index");
        idle(2);
        // mixed random vectors, back to back
        for (int k = 0; k < 300; k++) begin
            logic [31:0] w;
            w = mk(1'($urandom), 1'($urandom), 2'($urandom), 4'($urandom));
            apply(w, 16'($urandom), 16'($urandom), 16'($urandom), int'($urandom % 19),
                  "R3 R5 R6 R7 R8 R9 random");
            if (($urandom % 4) == 0) idle(1);
        end
        idle(4);
        if (q.size() != 0) begin
            miscompares++;
            $display("FAIL R1: pending results actual %0d expected 0", q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule